// File: doc/BRIEF.md
# Burst Bus Initiator with Retry and Wide Addressing

This block is the master side of a shared, multiplexed address/data bus. A local client gives it a start address, a word count and a direction. The block asks an external arbiter for the bus and waits for a grant. It then sends the command and address and runs the data phases. Write words come from a show-ahead source. Read words go out on a one-cycle valid strobe.

Addresses are twice the data width. When the upper half of the current address is zero, the block sends a single address phase. Otherwise it sends the low half under a dual-address command and then the high half under the real command. The initiator adds its own wait states by holding its ready low while it has no write word to offer.

A target can end a transaction early with a stop indication. The block then releases the bus, keeps the address of the first word not yet moved, requests the bus again and resumes from that address. A target that never claims the transaction causes an abort with an error flag.

Top module: `bus_initiator`

## Requirements
- R1: After reset `ready` is 1 and `bus_req`, `bus_frame`, `bus_irdy`, `ad_oe`, `done` and `err` are 0. A `start` pulse with `start_count` equal to 0 is ignored: `ready` stays 1 and `bus_req` stays 0.
- R2: An accepted start raises `bus_req` in the next cycle. `bus_req` stays high until `bus_gnt` is sampled high at a rising edge. In the cycle after that edge, `bus_frame` and `ad_oe` are 1 and `bus_req` is 0.
- R3: If bits [63:32] of the current address are zero, there is one address phase: `ad_out` carries the low half and `cbe_out` carries the command (0110 read, 0111 write). Otherwise there are two address phases. The first carries the low half with `cbe_out`=1101. The second carries the high half with the command.
- R4: A word moves at a rising edge where `bus_irdy`, `tgt_trdy` and `tgt_devsel` are all 1. During data phases `cbe_out` is 0000. On writes, `ad_oe` is 1 and `ad_out` holds the word. On reads, `ad_oe` is 0, `ad_in` is captured, and it appears on `rd_data` with `rd_valid` high for one cycle in the next cycle.
- R5: Write words are taken from the client in order. `wr_pop` is high in a cycle where `wr_valid` is high and a word is consumed. While no write word is held during a data phase, `bus_irdy` is 0 (initiator wait state). A held word stays on `ad_out` until it moves.
- R6: `bus_frame` is 0 in a data phase exactly when `bus_irdy` is 1 and one word remains. Once dropped, it stays low and `bus_irdy` stays high until that phase ends.
- R7: A data phase that samples `tgt_stop` and `tgt_devsel` high ends the transaction. If `tgt_trdy` is also high, that phase's word still moves. The next cycle has `bus_frame`, `bus_irdy` and `ad_oe` at 0, and `bus_req` is 1 if words remain. The block then re-arbitrates and restarts at the first unmoved word's address. No word is lost or repeated.
- R8: If `tgt_devsel` is never high during the first DEVSEL_WAIT data-phase cycles of a transaction, the transaction is aborted. One idle cycle follows, then `done` and `err` pulse together.
- R9: After the final word moves, there is one idle cycle with `bus_frame`, `bus_irdy`, `ad_oe` and `bus_req` at 0. Next comes one cycle with `done`=1, `err`=0 and `ready`=1.
- R10: The current address advances by 4 per moved word, with carry into the upper half. A retry after crossing a 4 GiB boundary therefore uses two address phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request pulse, taken while `ready` |
| start_addr | input | 64 | Byte address of the first word |
| start_count | input | 8 | Number of words |
| start_write | input | 1 | 1 = write, 0 = read |
| ready | output | 1 | Block is idle and accepts a request |
| done | output | 1 | One-cycle pulse when a request finishes |
| err | output | 1 | One-cycle pulse with `done` after an abort |
| wr_valid | input | 1 | Client write word available |
| wr_data | input | 32 | Client write word |
| wr_pop | output | 1 | Client write word taken this cycle |
| rd_valid | output | 1 | Read word valid |
| rd_data | output | 32 | Read word |
| bus_req | output | 1 | Request to the arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_frame | output | 1 | Transaction active, low in the final phase |
| bus_irdy | output | 1 | Initiator ready |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| ad_out | output | 32 | Address or write data driven to the bus |
| cbe_out | output | 4 | Command in address phases, byte enables in data phases |
| ad_in | input | 32 | Read data from the bus |
| tgt_trdy | input | 1 | Target ready |
| tgt_stop | input | 1 | Target requests termination |
| tgt_devsel | input | 1 | Target has claimed the transaction |

## Verification
In a single data phase, a target's stop request can coincide with a word moving. The word counter and the address counter must then advance once, and the same edge must also end the transaction. The bench provokes this with a target that raises stop and ready together on the third phase of a read. It judges the result by the restart address, which must point past the word that moved, and by the read stream, which must match the expected pattern word for word without a gap or a repeat. A second case stops without data just before a 4 GiB carry. The retry must then switch from one address phase to two.

// File: rtl/bi_pkg.sv
package bi_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ARB,
    S_ADR_LO,
    S_ADR_HI,
    S_DATA,
    S_TURN
  } bi_state_e;

  localparam logic [3:0] CMD_RD   = 4'b0110;
  localparam logic [3:0] CMD_WR   = 4'b0111;
  localparam logic [3:0] CMD_DUAL = 4'b1101;
  localparam logic [3:0] BE_ALL   = 4'b0000;
endpackage

// File: rtl/bi_addr_track.sv
module bi_addr_track #(
  parameter int AW = 64,
  parameter int CW = 8,
  parameter int INC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [CW-1:0] load_cnt,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] rem
);
  localparam logic [AW-1:0] STEP_A = AW'(INC);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      rem      <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      rem      <= load_cnt;
    end else if (step) begin
      cur_addr <= cur_addr + STEP_A;
      rem      <= rem - ONE_C;
    end
  end

  // R10: each moved word advances the address by one word
  a_r10_addr_step: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (cur_addr == $past(cur_addr) + STEP_A));
endmodule

// File: rtl/bi_wr_stage.sv
module bi_wr_stage #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_cnt,
  input  logic          active,
  input  logic          is_write,
  input  logic          take,
  input  logic          src_valid,
  input  logic [DW-1:0] src_data,
  output logic          pop,
  output logic          have,
  output logic [DW-1:0] word
);
  logic [CW-1:0] left_q;

  assign pop = active && is_write && src_valid && (left_q != '0) && (!have || take);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
      have   <= 1'b0;
      word   <= '0;
    end else if (load) begin
      left_q <= load_cnt;
      have   <= 1'b0;
    end else if (!active) begin
      have   <= 1'b0;
    end else if (pop) begin
      word   <= src_data;
      left_q <= left_q - CW'(1);
      have   <= 1'b1;
    end else if (take) begin
      have   <= 1'b0;
    end
  end

  // R5: a held word stays put until the bus takes it
  a_r5_hold_word: assert property (@(posedge clk) disable iff (rst)
    (have && !take && active && !load) |=> (have && $stable(word)));
endmodule

// File: rtl/bi_devsel_watch.sv
module bi_devsel_watch #(
  parameter int LIMIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic active,
  input  logic devsel,
  output logic timeout
);
  localparam int TW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

  logic [TW-1:0] cnt_q;
  logic          seen_q;

  assign timeout = active && !seen_q && !devsel && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else if (active) begin
      if (devsel)       seen_q <= 1'b1;
      else if (!seen_q) cnt_q  <= cnt_q + TW'(1);
    end
  end

  // R8: a claim in this transaction rules out a later abort
  a_r8_claim_blocks: assert property (@(posedge clk) disable iff (rst)
    (active && devsel && !clear) |=> !timeout);
endmodule

// File: rtl/bus_initiator.sv
module bus_initiator
  import bi_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int DEVSEL_WAIT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*DW-1:0] start_addr,
  input  logic [CW-1:0]   start_count,
  input  logic            start_write,
  output logic            ready,
  output logic            done,
  output logic            err,
  input  logic            wr_valid,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_pop,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            bus_req,
  input  logic            bus_gnt,
  output logic            bus_frame,
  output logic            bus_irdy,
  output logic            ad_oe,
  output logic [DW-1:0]   ad_out,
  output logic [3:0]      cbe_out,
  input  logic [DW-1:0]   ad_in,
  input  logic            tgt_trdy,
  input  logic            tgt_stop,
  input  logic            tgt_devsel
);
  localparam int AW = 2 * DW;
  localparam int BYTES = DW / 8;

  bi_state_e     st;
  logic          dir_q, aborted_q, done_q, err_q, rd_valid_q;
  logic [DW-1:0] rd_q;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] rem;
  logic          have;
  logic [DW-1:0] word;
  logic          timeout;
  logic          accept, irdy_c, xfer, stop_ev, last_word, upper_nz;
  logic [3:0]    cmd;

  assign accept    = (st == S_IDLE) && start && (start_count != '0);
  assign irdy_c    = (st == S_DATA) && (dir_q ? have : 1'b1);
  assign xfer      = irdy_c && tgt_trdy && tgt_devsel;
  assign stop_ev   = (st == S_DATA) && tgt_stop && tgt_devsel;
  assign last_word = (rem == CW'(1));
  assign upper_nz  = |cur_addr[AW-1:DW];
  assign cmd       = dir_q ? CMD_WR : CMD_RD;

  bi_addr_track #(.AW(AW), .CW(CW), .INC(BYTES)) u_track (
    .clk(clk), .rst(rst), .load(accept), .load_addr(start_addr),
    .load_cnt(start_count), .step(xfer), .cur_addr(cur_addr), .rem(rem)
  );

  bi_wr_stage #(.DW(DW), .CW(CW)) u_wr (
    .clk(clk), .rst(rst), .load(accept), .load_cnt(start_count),
    .active(st != S_IDLE), .is_write(dir_q), .take(xfer && dir_q),
    .src_valid(wr_valid), .src_data(wr_data), .pop(wr_pop),
    .have(have), .word(word)
  );

  bi_devsel_watch #(.LIMIT(DEVSEL_WAIT)) u_watch (
    .clk(clk), .rst(rst), .clear(st == S_ADR_LO), .active(st == S_DATA),
    .devsel(tgt_devsel), .timeout(timeout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      dir_q      <= 1'b0;
      aborted_q  <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      rd_q       <= '0;
    end else begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rd_valid_q <= 1'b0;
      if (xfer && !dir_q) begin
        rd_q       <= ad_in;
        rd_valid_q <= 1'b1;
      end
      unique case (st)
        S_IDLE: if (accept) begin
          dir_q     <= start_write;
          aborted_q <= 1'b0;
          st        <= S_ARB;
        end
        S_ARB:    if (bus_gnt) st <= S_ADR_LO;
        S_ADR_LO: st <= upper_nz ? S_ADR_HI : S_DATA;
        S_ADR_HI: st <= S_DATA;
        S_DATA: begin
          if (timeout) begin
            aborted_q <= 1'b1;
            st        <= S_TURN;
          end else if ((xfer && last_word) || stop_ev) begin
            st <= S_TURN;
          end
        end
        S_TURN: begin
          if (aborted_q || rem == '0) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            err_q  <= aborted_q;
          end else begin
            st <= S_ARB;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign ready     = (st == S_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_q;
  assign bus_req   = (st == S_ARB) || ((st == S_TURN) && (rem != '0) && !aborted_q);
  assign bus_irdy  = irdy_c;
  assign bus_frame = (st == S_ADR_LO) || (st == S_ADR_HI) ||
                     ((st == S_DATA) && !(last_word && irdy_c));
  assign ad_oe     = (st == S_ADR_LO) || (st == S_ADR_HI) || ((st == S_DATA) && dir_q);

  always_comb begin
    unique case (st)
      S_ADR_LO: begin
        ad_out  = cur_addr[DW-1:0];
        cbe_out = upper_nz ? CMD_DUAL : cmd;
      end
      S_ADR_HI: begin
        ad_out  = cur_addr[AW-1:DW];
        cbe_out = cmd;
      end
      default: begin
        ad_out  = word;
        cbe_out = BE_ALL;
      end
    endcase
  end

  // R2: a sampled grant opens the transaction and drops the request
  a_r2_grant_opens: assert property (@(posedge clk) disable iff (rst)
    (st == S_ARB && bus_gnt) |=> (bus_frame && ad_oe && !bus_req));

  // R3: a dual-address first phase is followed by a second address phase
  a_r3_dual_second: assert property (@(posedge clk) disable iff (rst)
    (bus_frame && ad_oe && cbe_out == CMD_DUAL) |=> (bus_frame && ad_oe && cbe_out != CMD_DUAL));

  // R6: once frame drops in a data phase it stays low with irdy held
  a_r6_frame_stays_low: assert property (@(posedge clk) disable iff (rst)
    (bus_irdy && !bus_frame && !xfer && !stop_ev && !timeout) |=> (bus_irdy && !bus_frame));

  // R7: a stop leaves the bus idle and keeps asking while words remain
  a_r7_stop_rearb: assert property (@(posedge clk) disable iff (rst)
    (stop_ev && !(xfer && last_word)) |=> (bus_req && !bus_frame && !bus_irdy && !ad_oe));

  // R8: an abort reports done together with err after one idle cycle
  a_r8_abort_report: assert property (@(posedge clk) disable iff (rst)
    timeout |=> ##1 (done && err));

  // R9: final word, idle turnaround, then completion
  a_r9_turnaround: assert property (@(posedge clk) disable iff (rst)
    (xfer && !bus_frame) |=> (!bus_frame && !bus_irdy && !ad_oe) ##1 (done && ready));
endmodule

// File: tb/bus_initiator_bench.sv
`timescale 1ns/1ps
module bus_initiator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [63:0] s_addr = '0;
  logic [7:0]  s_count = '0;
  logic        s_write = 1'b0;
  logic        ready, done, err, wr_pop, rd_valid;
  logic        wr_valid;
  logic [31:0] wr_data, rd_data;
  logic        bus_req, bus_frame, bus_irdy, ad_oe;
  logic        bus_gnt = 1'b0;
  logic [31:0] ad_out;
  logic [3:0]  cbe_out;
  logic [31:0] ad_in = '0;
  logic        tgt_trdy = 1'b0, tgt_stop = 1'b0, tgt_devsel = 1'b0;

  always #4 clk = ~clk;

  bus_initiator u_bus_initiator (
    .clk(clk), .rst(rst), .start(start), .start_addr(s_addr),
    .start_count(s_count), .start_write(s_write), .ready(ready),
    .done(done), .err(err), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_pop(wr_pop), .rd_valid(rd_valid), .rd_data(rd_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_frame(bus_frame),
    .bus_irdy(bus_irdy), .ad_oe(ad_oe), .ad_out(ad_out), .cbe_out(cbe_out),
    .ad_in(ad_in), .tgt_trdy(tgt_trdy), .tgt_stop(tgt_stop), .tgt_devsel(tgt_devsel)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rdpat(input logic [63:0] a);
    return a[31:0] ^ 32'h5A5A_0000 ^ a[63:32];
  endfunction

  // write source
  int widx = 0, wn = 0, cyc = 0;
  bit src_clr = 0, stall_src = 0;
  assign wr_valid = (widx < wn) && !(stall_src && (cyc % 3 != 0));
  assign wr_data  = 32'h7700_0000 + 32'(widx);
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (src_clr) widx <= 0;
    else if (wr_pop) widx <= widx + 1;
  end

  // target, arbiter and monitors
  int gdly = 1, rq_cnt = 0;
  int tstate = 0, dcyc = 0, txn_words = 0, last_dcyc = 0;
  logic [31:0] t_lo;
  logic [63:0] t_addr;
  logic [3:0]  t_cmd;
  bit stop_armed = 0, cfg_stop_data = 0, cfg_waits = 0;
  int cfg_stop_after = 0, cfg_devsel_dly = 0;
  logic [63:0] wlog_addr [64];
  logic [31:0] wlog_data [64];
  logic [31:0] rlog [64];
  logic [31:0] aph_lo [8], aph_hi [8];
  logic [3:0]  aph_cmd [8];
  bit          aph_dual [8];
  int wn_log = 0, rn = 0, an = 0, moved = 0, exp_total = 0, irdy_low_cnt = 0;
  int fin_stage = 0;
  bit stop_prev = 0, done_seen = 0, err_seen = 0;

  always @(negedge clk) begin
    if (rst) begin
      tstate = 0; bus_gnt = 0; rq_cnt = 0;
      tgt_trdy = 0; tgt_stop = 0; tgt_devsel = 0; ad_in = '0;
    end else begin
      if (bus_gnt) chk(bus_frame && ad_oe && !bus_req, "R2 open after grant",
                       {61'd0, bus_frame, ad_oe, bus_req}, 64'b110);
      if (fin_stage == 2) begin
        chk(done && ready && !err, "R9 done after turnaround", {61'd0, done, ready, err}, 64'b110);
        fin_stage = 0;
      end
      if (fin_stage == 1) begin
        chk(!bus_frame && !bus_irdy && !ad_oe && !bus_req, "R9 idle turnaround",
            {60'd0, bus_frame, bus_irdy, ad_oe, bus_req}, 64'd0);
        fin_stage = 2;
      end
      if (stop_prev) begin
        chk(!bus_frame && !bus_irdy && !ad_oe && (bus_req == (moved < exp_total)),
            "R7 turnaround after stop", {60'd0, bus_frame, bus_irdy, ad_oe, bus_req},
            {63'd0, moved < exp_total});
        stop_prev = 0;
      end
      if (done) done_seen = 1;
      if (err) err_seen = 1;
      if (rd_valid) begin rlog[rn] = rd_data; rn++; end

      tgt_trdy = 0; tgt_stop = 0; tgt_devsel = 0; ad_in = '0;
      case (tstate)
        0: if (bus_frame && ad_oe) begin
          if (cbe_out == 4'b1101) begin
            t_lo = ad_out; tstate = 1;
          end else begin
            aph_lo[an] = ad_out; aph_hi[an] = '0; aph_dual[an] = 0; aph_cmd[an] = cbe_out; an++;
            t_addr = {32'd0, ad_out}; t_cmd = cbe_out; tstate = 2; dcyc = 0; txn_words = 0;
          end
        end
        1: begin
          aph_lo[an] = t_lo; aph_hi[an] = ad_out; aph_dual[an] = 1; aph_cmd[an] = cbe_out; an++;
          t_addr = {ad_out, t_lo}; t_cmd = cbe_out; tstate = 2; dcyc = 0; txn_words = 0;
        end
        default: begin
          if (!bus_frame && !bus_irdy) begin
            last_dcyc = dcyc; tstate = 0;
          end else begin
            bit dv, sp, tr;
            chk(cbe_out == 4'b0000 && ad_oe == (t_cmd == 4'b0111), "R4 data phase drive",
                {59'd0, ad_oe, cbe_out}, {59'd0, (t_cmd == 4'b0111), 4'b0000});
            dv = (dcyc >= cfg_devsel_dly);
            sp = dv && stop_armed && (txn_words == cfg_stop_after);
            tr = dv && (!cfg_waits || dcyc[0]);
            if (sp) tr = cfg_stop_data;
            tgt_devsel = dv; tgt_trdy = tr; tgt_stop = sp; ad_in = rdpat(t_addr);
            if (!bus_irdy && bus_frame) irdy_low_cnt++;
            if (bus_irdy) chk(bus_frame == ((exp_total - moved) != 1), "R6 frame marks last phase",
                              {63'd0, bus_frame}, {63'd0, (exp_total - moved) != 1});
            if (bus_irdy && tr && dv) begin
              if (t_cmd == 4'b0111) begin
                wlog_addr[wn_log] = t_addr; wlog_data[wn_log] = ad_out; wn_log++;
              end
              t_addr = t_addr + 64'd4; txn_words++; moved++;
              if (!bus_frame) fin_stage = 1;
            end
            if (sp) begin stop_armed = 0; stop_prev = 1; end
            dcyc++;
          end
        end
      endcase

      if (bus_req) begin
        rq_cnt++;
        bus_gnt = (rq_cnt > gdly);
      end else begin
        rq_cnt = 0;
        bus_gnt = 0;
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic run_txn(input logic [63:0] a, input int n, input bit w);
    tick();
    src_clr = 1; wn = w ? n : 0;
    wn_log = 0; rn = 0; an = 0; moved = 0; exp_total = n; irdy_low_cnt = 0;
    done_seen = 0; err_seen = 0;
    tick();
    src_clr = 0;
    start = 1; s_addr = a; s_count = 8'(n); s_write = w;
    tick();
    start = 0;
    for (int i = 0; i < 3000 && !done_seen; i++) tick();
    chk(done_seen, "R9 request completes", {63'd0, done_seen}, 64'd1);
    tick();
  endtask

  task automatic cfg(input int gd, input int dsl, input bit waits, input bit stop_on,
                     input int stop_at, input bit stop_data, input bit stall);
    gdly = gd; cfg_devsel_dly = dsl; cfg_waits = waits; stop_armed = stop_on;
    cfg_stop_after = stop_at; cfg_stop_data = stop_data; stall_src = stall;
  endtask

  task automatic check_writes(input logic [63:0] a, input int n, input string req);
    chk(wn_log == n, req, 64'(wn_log), 64'(n));
    for (int k = 0; k < n && k < wn_log; k++) begin
      chk(wlog_addr[k] == a + 64'(4 * k), req, wlog_addr[k], a + 64'(4 * k));
      chk(wlog_data[k] == 32'h7700_0000 + 32'(k), req, 64'(wlog_data[k]), 64'(32'h7700_0000 + 32'(k)));
    end
  endtask

  task automatic check_reads(input logic [63:0] a, input int n, input string req);
    chk(rn == n, req, 64'(rn), 64'(n));
    for (int k = 0; k < n && k < rn; k++)
      chk(rlog[k] == rdpat(a + 64'(4 * k)), req, 64'(rlog[k]), 64'(rdpat(a + 64'(4 * k))));
  endtask

  task automatic t_reset();
    chk(ready && !bus_req && !bus_frame && !bus_irdy && !ad_oe && !done && !err, "R1 reset state",
        {58'd0, ready, bus_req, bus_frame, bus_irdy, ad_oe, done | err}, 64'b100000);
  endtask

  task automatic t_zero_count();
    start = 1; s_count = 8'd0; s_addr = 64'h100;
    tick();
    start = 0;
    repeat (3) begin
      tick();
      chk(ready && !bus_req, "R1 zero count ignored", {62'd0, ready, bus_req}, 64'b10);
    end
  endtask

  task automatic t_write_basic();
    cfg(2, 0, 0, 0, 0, 0, 0);
    run_txn(64'h1000, 5, 1);
    chk(an == 1 && !aph_dual[0], "R3 single address phase", 64'(an), 64'd1);
    chk(aph_lo[0] == 32'h1000 && aph_cmd[0] == 4'b0111, "R3 write command and address",
        {28'd0, aph_cmd[0], aph_lo[0]}, {28'd0, 4'b0111, 32'h1000});
    check_writes(64'h1000, 5, "R4 write words");
    chk(!err_seen, "R9 no error", {63'd0, err_seen}, 64'd0);
  endtask

  task automatic t_read_dual();
    cfg(1, 1, 1, 0, 0, 0, 0);
    run_txn(64'h0000_0002_0000_0040, 4, 0);
    chk(an == 1 && aph_dual[0], "R3 dual address phase", {31'd0, aph_dual[0], 32'(an)}, {31'd0, 1'b1, 32'd1});
    chk(aph_lo[0] == 32'h40 && aph_hi[0] == 32'h2 && aph_cmd[0] == 4'b0110, "R3 dual halves and read command",
        {aph_hi[0], aph_lo[0]}, 64'h0000_0002_0000_0040);
    check_reads(64'h0000_0002_0000_0040, 4, "R4 read words");
  endtask

  task automatic t_write_stall();
    cfg(1, 0, 0, 0, 0, 0, 1);
    run_txn(64'h2000, 6, 1);
    chk(irdy_low_cnt > 0, "R5 initiator wait states", 64'(irdy_low_cnt), 64'd1);
    check_writes(64'h2000, 6, "R5 stalled write order");
    stall_src = 0;
  endtask

  task automatic t_stop_resume();
    cfg(1, 0, 0, 1, 2, 1, 0);
    run_txn(64'h3000, 6, 0);
    chk(an == 2, "R7 re-arbitrated once", 64'(an), 64'd2);
    chk(aph_lo[1] == 32'h300C && !aph_dual[1], "R7 restart address", 64'(aph_lo[1]), 64'h300C);
    check_reads(64'h3000, 6, "R7 no loss or repeat");
  endtask

  task automatic t_stop_cross();
    cfg(1, 0, 0, 1, 2, 0, 0);
    run_txn(64'h0000_0000_FFFF_FFF8, 4, 1);
    chk(an == 2 && !aph_dual[0] && aph_lo[0] == 32'hFFFF_FFF8, "R10 first phase single",
        {aph_lo[0], 32'(an)}, {32'hFFFF_FFF8, 32'd2});
    chk(aph_dual[1] && aph_lo[1] == 32'h0 && aph_hi[1] == 32'h1, "R10 retry goes dual",
        {aph_hi[1], aph_lo[1]}, 64'h0000_0001_0000_0000);
    check_writes(64'h0000_0000_FFFF_FFF8, 4, "R10 carry addresses");
  endtask

  task automatic t_abort();
    cfg(1, 100, 0, 0, 0, 0, 0);
    run_txn(64'h4000, 4, 0);
    chk(err_seen, "R8 error flag", {63'd0, err_seen}, 64'd1);
    chk(rn == 0, "R8 no data", 64'(rn), 64'd0);
    chk(last_dcyc == 5, "R8 timeout window", 64'(last_dcyc), 64'd5);
    chk(ready, "R8 back to idle", {63'd0, ready}, 64'd1);
    cfg_devsel_dly = 0;
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    tick();
    rst = 0;
    tick();
    t_reset();
    t_zero_count();
    t_write_basic();
    t_read_dual();
    t_write_stall();
    t_stop_resume();
    t_stop_cross();
    t_abort();
    finish_up();
  end
endmodule